// File: doc/BRIEF.md
# Bitplane Word to Pixel Colour Extractor

This block picks one pixel out of a 16-bit memory word and turns it into a 16-bit colour value. The size of the pixel is set by a bits-per-pixel code. A target index says which sub-pixel in the word is wanted, counting from the most significant end. The result for low colour depths is offset by a colour base input, which moves a small pixel value into a chosen band of the output colour space.

Two complete source sets are offered: one holds the values that come with a memory return, and the other holds the values kept in a cache. Each set has a word, a depth code and a target. A ready flag picks the immediate set. This means a cache miss yields its colour in the same cycle the memory data shows up, instead of one cycle later after the cache has been written.

The block is purely combinational. It has no clock and no reset.

Top module: `pixel_word_extract`

## Requirements
- R1: When `dataReady` is 1, the output is computed only from `immWord`, `immBpp` and `immTarget`. When `dataReady` is 0, it is computed only from `latWord`, `latBpp` and `latTarget`.
- R2: Depth code 4 means 16 bits per pixel. The output is the whole selected word, and both the target and `colourBase` have no effect.
- R3: Depth code 3 means 8 bits per pixel. Target bit 0 equal to 0 selects word bits 15:8, and equal to 1 selects bits 7:0. Target bits 3:1 are ignored.
- R4: Depth code 2 means 4 bits per pixel. Target bits 1:0 set to t select word bits (15-4t):(12-4t). Target bits 3:2 are ignored.
- R5: Depth code 1 means 2 bits per pixel. Target bits 2:0 set to t select word bits (15-2t):(14-2t). Target bit 3 is ignored.
- R6: Depth code 0 means 1 bit per pixel. Target t selects word bit 15-t.
- R7: For depth codes 0 to 3, the output is the extracted field, zero-extended, plus `colourBase`, taken modulo 2^16.
- R8: Depth codes 5 to 15 give an output of 16'h0000, whatever the word, target and base are.
- R9: The output follows any input change within the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataReady | input | 1 | High while memory return data is valid; selects the immediate source set |
| immWord | input | 16 | Word arriving from memory |
| immBpp | input | 4 | Depth code that goes with the memory word |
| immTarget | input | 4 | Sub-pixel index that goes with the memory word |
| latWord | input | 16 | Cached word |
| latBpp | input | 4 | Cached depth code |
| latTarget | input | 4 | Cached sub-pixel index |
| colourBase | input | 16 | Offset added to pixels narrower than 16 bits |
| pixColour | output | 16 | Resulting colour |

## Verification
In a single evaluation, source selection and depth-dependent extraction with base addition act together. The bench provokes this by giving the immediate and cached sets different depth codes, targets and words, then toggling `dataReady` between otherwise identical stimuli. A selection error then shows up as a wrong field width or a wrong field position, not merely as a wrong word. Each result is judged against a reference model: it computes the field offset directly from the depth and the target, and it is fed only the set that the ready flag names.

// File: rtl/pixExtractPkg.sv
package pixExtractPkg;
  // Word geometry; all other widths derive from it.
  parameter int PIX_WORD_W = 16;
  localparam int PIX_MODES = $clog2(PIX_WORD_W) + 1;   // 1,2,4,8,16 bpp
  localparam int PIX_TGT_W = $clog2(PIX_WORD_W);
  localparam int PIX_BPP_W = 4;

  // Strobes handed from the mode control to the extraction datapath.
  typedef struct packed {
    logic                 useImmediate;
    logic [PIX_MODES-1:0] modeHot;
    logic [PIX_TGT_W-1:0] target;
  } pixStrobes_t;
endpackage

// File: rtl/pixModeCtrl.sv
module pixModeCtrl
  import pixExtractPkg::*;
(
  input  logic                 dataReady,
  input  logic [PIX_BPP_W-1:0] immBpp,
  input  logic [PIX_BPP_W-1:0] latBpp,
  input  logic [PIX_TGT_W-1:0] immTarget,
  input  logic [PIX_TGT_W-1:0] latTarget,
  output pixStrobes_t          strobes
);
  logic [PIX_BPP_W-1:0] selBpp;
  logic [PIX_MODES-1:0] modeVec;

  assign selBpp = dataReady ? immBpp : latBpp;

  // One decoder per supported depth; any other code raises no strobe.
  for (genvar m = 0; m < PIX_MODES; m++) begin : g_dec
    assign modeVec[m] = (selBpp == PIX_BPP_W'(m));
  end

  always_comb begin
    strobes.useImmediate = dataReady;
    strobes.modeHot      = modeVec;
    strobes.target       = dataReady ? immTarget : latTarget;
  end

  // R8: a legal code raises exactly one strobe, an illegal code none.
  always_comb begin
    if (selBpp < PIX_BPP_W'(PIX_MODES)) begin
      assert_mode_decode_R8: assert ($onehot(modeVec))
        else $error("legal depth code did not raise one strobe");
    end else begin
      assert_mode_silent_R8: assert (modeVec == '0)
        else $error("illegal depth code raised a strobe");
    end
  end
endmodule

// File: rtl/pixExtractPath.sv
module pixExtractPath
  import pixExtractPkg::*;
(
  input  pixStrobes_t           strobes,
  input  logic [PIX_WORD_W-1:0] immWord,
  input  logic [PIX_WORD_W-1:0] latWord,
  input  logic [PIX_WORD_W-1:0] colourBase,
  output logic [PIX_WORD_W-1:0] pixColour
);
  logic [PIX_WORD_W-1:0]                 srcWord;
  logic [PIX_MODES-1:0][PIX_WORD_W-1:0] fieldVal;
  logic [PIX_WORD_W-1:0]                 pixVal;

  assign srcWord = strobes.useImmediate ? immWord : latWord;

  // One extractor per depth. Sub-pixel 0 sits at the top of the word.
  for (genvar m = 0; m < PIX_MODES; m++) begin : g_mode
    localparam int PW = 1 << m;
    localparam int NF = PIX_WORD_W / PW;
    localparam logic [PIX_WORD_W-1:0] MASK = PIX_WORD_W'((64'd1 << PW) - 1);
    logic [PIX_TGT_W-1:0]  revIdx;
    logic [PIX_WORD_W-1:0] shifted;
    // Only the low target bits that address a field at this depth count.
    assign revIdx  = ~strobes.target & PIX_TGT_W'(NF - 1);
    assign shifted = srcWord >> (int'(revIdx) << m);
    assign fieldVal[m] = strobes.modeHot[m] ? (shifted & MASK) : '0;
  end

  always_comb begin
    pixVal = '0;
    for (int m = 0; m < PIX_MODES; m++) pixVal = pixVal | fieldVal[m];
    if (strobes.modeHot[PIX_MODES-1])
      pixColour = pixVal;
    else if (|strobes.modeHot)
      pixColour = pixVal + colourBase;
    else
      pixColour = '0;
  end
endmodule

// File: rtl/pixel_word_extract.sv
module pixel_word_extract
  import pixExtractPkg::*;
(
  input  logic                  dataReady,
  input  logic [PIX_WORD_W-1:0] immWord,
  input  logic [PIX_BPP_W-1:0]  immBpp,
  input  logic [PIX_TGT_W-1:0]  immTarget,
  input  logic [PIX_WORD_W-1:0] latWord,
  input  logic [PIX_BPP_W-1:0]  latBpp,
  input  logic [PIX_TGT_W-1:0]  latTarget,
  input  logic [PIX_WORD_W-1:0] colourBase,
  output logic [PIX_WORD_W-1:0] pixColour
);
  pixStrobes_t strobes;

  pixModeCtrl u_ctrl (
    .dataReady (dataReady),
    .immBpp    (immBpp),
    .latBpp    (latBpp),
    .immTarget (immTarget),
    .latTarget (latTarget),
    .strobes   (strobes)
  );

  pixExtractPath u_path (
    .strobes    (strobes),
    .immWord    (immWord),
    .latWord    (latWord),
    .colourBase (colourBase),
    .pixColour  (pixColour)
  );

  // Port-level relations between the control and datapath halves.
  logic [PIX_BPP_W-1:0]  chkBpp;
  logic [PIX_WORD_W-1:0] chkWord;
  logic [PIX_WORD_W-1:0] chkOffset;
  always_comb begin
    chkBpp    = dataReady ? immBpp : latBpp;
    chkWord   = dataReady ? immWord : latWord;
    chkOffset = pixColour - colourBase;
    if (chkBpp >= PIX_BPP_W'(PIX_MODES)) begin
      assert_invalid_zero_R8: assert (pixColour == '0)
        else $error("illegal depth gave nonzero colour");
    end
    if (chkBpp == PIX_BPP_W'(PIX_MODES - 1)) begin
      assert_full_word_R2: assert (pixColour == chkWord)
        else $error("full depth did not pass the word");
    end
    if (chkBpp == PIX_BPP_W'(0)) begin
      assert_one_bit_range_R6: assert (chkOffset <= PIX_WORD_W'(1))
        else $error("single-bit pixel out of range");
    end
    if (chkBpp == PIX_BPP_W'(PIX_MODES - 2)) begin
      assert_byte_range_R3: assert (chkOffset < PIX_WORD_W'(256))
        else $error("byte pixel out of range");
    end
  end
endmodule

// File: tb/pixel_word_extract_bench.sv
`timescale 1ns/1ps
module pixel_word_extract_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        dataReady = 1'b0;
  logic [15:0] immWord = '0, latWord = '0, colourBase = '0;
  logic [3:0]  immBpp = '0, latBpp = '0, immTarget = '0, latTarget = '0;
  logic [15:0] pixColour;

  pixel_word_extract u_pixel_word_extract (
    .dataReady(dataReady), .immWord(immWord), .immBpp(immBpp), .immTarget(immTarget),
    .latWord(latWord), .latBpp(latBpp), .latTarget(latTarget),
    .colourBase(colourBase), .pixColour(pixColour));

  typedef struct {
    logic [15:0] value;
    string       tag;
  } expItem_t;
  expItem_t scoreQ[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference: field offset taken straight from depth and target.
  function automatic logic [15:0] refColour(logic [3:0] bpp, logic [3:0] tgt,
                                            logic [15:0] word, logic [15:0] base);
    int w;
    int k;
    int v;
    case (bpp)
      4'd0: w = 1;
      4'd1: w = 2;
      4'd2: w = 4;
      4'd3: w = 8;
      4'd4: return word;
      default: return 16'h0000;
    endcase
    k = int'(tgt) % (16 / w);
    v = (int'(word) >> (16 - w * (k + 1))) & ((1 << w) - 1);
    return 16'(v + int'(base));
  endfunction

  task automatic drive(input logic rdy,
                       input logic [15:0] iw, input logic [3:0] ib, input logic [3:0] it,
                       input logic [15:0] lw, input logic [3:0] lb, input logic [3:0] lt,
                       input logic [15:0] base, input string tag);
    expItem_t e;
    @(posedge clk);
    dataReady = rdy; immWord = iw; immBpp = ib; immTarget = it;
    latWord = lw; latBpp = lb; latTarget = lt; colourBase = base;
    e.value = rdy ? refColour(ib, it, iw, base) : refColour(lb, lt, lw, base);
    e.tag = tag;
    scoreQ.push_back(e);
  endtask

  // Monitor: compare away from the driving edge.
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      checks++;
      if (pixColour !== e.value) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", e.tag, pixColour, e.value);
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset-state: all-zero inputs give zero colour
    drive(0, 16'h0, 4'd0, 4'd0, 16'h0, 4'd0, 4'd0, 16'h0, "R6 reset-state");
    // R2 full word, target and base ignored
    drive(1, 16'hBEEF, 4'd4, 4'd7, 16'h1234, 4'd0, 4'd0, 16'h5555, "R2 imm full word");
    drive(0, 16'hBEEF, 4'd0, 4'd0, 16'hC0DE, 4'd4, 4'd9, 16'hAAAA, "R2 lat full word");
    // R3 bytes, high target bits ignored
    drive(1, 16'hA55A, 4'd3, 4'd0, 16'h0, 4'd0, 4'd0, 16'h0, "R3 upper byte");
    drive(1, 16'hA55A, 4'd3, 4'd1, 16'h0, 4'd0, 4'd0, 16'h0, "R3 lower byte");
    drive(0, 16'h0, 4'd0, 4'd0, 16'h7E81, 4'd3, 4'd14, 16'h0100, "R3 target 14 acts as 0");
    // R4 nibbles
    for (int t = 0; t < 8; t++)
      drive(1, 16'h9C3F, 4'd2, 4'(t), 16'h0, 4'd0, 4'd0, 16'h0020, "R4 nibble");
    // R5 pairs
    for (int t = 0; t < 16; t++)
      drive(0, 16'hFFFF, 4'd4, 4'd0, 16'h6C1B, 4'd1, 4'(t), 16'h0004, "R5 pair");
    // R6 single bits
    for (int t = 0; t < 16; t++)
      drive(1, 16'hD2B4, 4'd0, 4'(t), 16'hFFFF, 4'd4, 4'd0, 16'h0010, "R6 bit");
    // R7 base wrap
    drive(1, 16'h8000, 4'd0, 4'd0, 16'h0, 4'd0, 4'd0, 16'hFFFF, "R7 base wrap");
    drive(1, 16'hF000, 4'd2, 4'd0, 16'h0, 4'd0, 4'd0, 16'hFFF8, "R7 nibble wrap");
    // R8 invalid codes on both sides
    for (int b = 5; b < 16; b++) begin
      drive(1, 16'hFFFF, 4'(b), 4'd3, 16'hFFFF, 4'd0, 4'd0, 16'h1111, "R8 invalid imm");
      drive(0, 16'hFFFF, 4'd3, 4'd3, 16'hFFFF, 4'(b), 4'd5, 16'h2222, "R8 invalid lat");
    end
    // R1 and R9: toggle ready with differing sets, result changes same cycle
    for (int i = 0; i < 6; i++) begin
      drive(1, 16'h35CA, 4'd3, 4'd1, 16'h35CA, 4'd0, 4'd2, 16'h0040, "R1 ready selects imm");
      drive(0, 16'h35CA, 4'd3, 4'd1, 16'h35CA, 4'd0, 4'd2, 16'h0040, "R9 ready low selects lat");
      drive(1, 16'h0F0F, 4'd9, 4'd0, 16'h8421, 4'd2, 4'd3, 16'h0, "R1 imm invalid vs lat");
      drive(0, 16'h0F0F, 4'd9, 4'd0, 16'h8421, 4'd2, 4'd3, 16'h0, "R1 lat nibble");
    end
    wait (scoreQ.size() == 0);
    @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule